// File: doc/BRIEF.md
# Multi-Way Run Merger with Per-Way Prefetch Queues

This block merges W runs that are already sorted by key, held in a read-only memory port, into one stream in ascending key order. Each way owns a fixed window of `RUN_MAX` words. The caller gives the length of each run and pulses `start`. A prefetcher visits one way per cycle in rotation. On its turn a way either issues one memory read or, once all its words have been requested, queues an end-of-run marker. Read data comes back exactly `LAT` cycles after the request. A short owner pipeline, as deep as the read latency, tells the block which way's queue each returned word belongs to.

Each way has a private queue. A credit count per way (words queued plus reads in flight) stops the queue from overflowing. A selector compares the W queue heads once every queue holds at least one entry. It pops the smallest key and registers that one item as the output. A marker counts as larger than any key. When every head is a marker, the block drops all markers, pulses `done` and returns to idle. No marker ever appears on the output. A new merge can only start after the previous one has fully drained.

Top module: `merge_stream_top`

## Requirements
- R1: After reset, `out_valid`, `done`, `rd_en` and `active` are all 0.
- R2: Within one merge, the keys on `out_valid` never decrease.
- R3: Every word of every run comes out exactly once, and nothing else comes out. A memory word holds the key in bits [KW+IW-1:IW] and the index in bits [IW-1:0].
- R4: When equal keys come from different ways, the item from the lower-numbered way comes out first. Equal keys within one way keep their memory order.
- R5: The run for way w is read from addresses w*RUN_MAX through w*RUN_MAX+len-1, and each of those addresses is read exactly once per merge. `run_len` carries way w's length in bits [w*LW +: LW].
- R6: A run of length 0 adds nothing to the output. If all runs are empty, the block still finishes with `done`.
- R7: `done` pulses for one cycle after the last item of a merge. It is never high in the same cycle as `out_valid`, and `active` is low from that cycle on.
- R8: A `start` pulse while `active` is high is ignored. The merge in progress keeps its lengths and its output.
- R9: `rd_en` is only high while `active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a merge; accepted only when idle |
| run_len | input | W*LW | Length of each run, way w in bits [w*LW +: LW] |
| active | output | 1 | A merge is in progress |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_data | input | KW+IW | Read data, valid LAT cycles after the request |
| out_valid | output | 1 | Merged item present |
| out_key | output | KW | Key of the merged item |
| out_idx | output | IW | Index payload of the merged item |
| done | output | 1 | One-cycle pulse at the end of a merge |

## Verification
The bench uses several run patterns, and each one separates a different kind of fault:
- **Strictly rising keys with unequal lengths** show whether the selector compares keys correctly and whether each way's address counter stops at the right point.
- **All keys equal** isolate the tie rule. With every key the same, only the index order reveals which way won each comparison.
- **Runs with empty ways, and a merge where every way is empty,** exercise a marker that is queued on a way's very first turn.
- **All four runs at full length** keep the queues at their credit limit for a long stretch.
- **A `start` pulse during a merge** shows whether the lengths are latched once and then held.

// File: rtl/merge_stream_pkg.sv
// Shared defaults for the run merger.
package merge_stream_pkg;
    localparam int unsigned DEF_WAYS    = 4;
    localparam int unsigned DEF_KEY_W   = 16;
    localparam int unsigned DEF_IDX_W   = 8;
    localparam int unsigned DEF_RUN_MAX = 16;
    localparam int unsigned DEF_LAT     = 4;
    localparam int unsigned DEF_QDEPTH  = 8;
endpackage

// File: rtl/merge_way_fifo.sv
// Per-way prefetch queue. Assumes DEPTH is a power of two and that the
// writer never pushes into a full queue (guaranteed by prefetch credits).
module merge_way_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic          empty,
    output logic [DW-1:0] head
);
    localparam int unsigned PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    // storage write
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= wdata;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (wr) wp <= wp + 1'b1;
            if (rd) rp <= rp + 1'b1;
            cnt <= cnt + {{PW{1'b0}}, wr} - {{PW{1'b0}}, rd};
        end
    end

    assign empty = (cnt == '0);
    assign head  = mem[rp];
endmodule

// File: rtl/merge_prefetch.sv
// Prefetcher: visits one way per cycle in rotation and either issues a read
// or queues an end-of-run marker. Keeps a credit count per way and an owner
// pipeline of depth LAT tagging each returned word. Assumes W is a power of
// two and that memory returns data exactly LAT cycles after rd_en.
module merge_prefetch #(
    parameter int unsigned W       = 4,
    parameter int unsigned RUN_MAX = 16,
    parameter int unsigned LAT     = 4,
    parameter int unsigned QDEPTH  = 8,
    localparam int unsigned WW = $clog2(W),
    localparam int unsigned OW = $clog2(RUN_MAX),
    localparam int unsigned LW = $clog2(RUN_MAX + 1),
    localparam int unsigned AW = WW + OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [W*LW-1:0] lens,
    input  logic [W-1:0]  pop,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          fill_valid,
    output logic [WW-1:0] fill_way,
    output logic          fill_eos
);
    localparam int unsigned CW = $clog2(QDEPTH + 1);

    logic [LW-1:0] len_q  [W];
    logic [LW-1:0] sent_q [W];
    logic [CW-1:0] cred_q [W];
    logic [W-1:0]  marked_q;
    logic [WW-1:0] rr_q;
    logic          own_v [LAT];
    logic [WW-1:0] own_w [LAT];
    logic          own_e [LAT];

    logic room, want_fetch, want_eos;

    // decision for the way whose turn it is
    always_comb begin
        room       = cred_q[rr_q] < CW'(QDEPTH);
        want_fetch = run && room && (sent_q[rr_q] < len_q[rr_q]);
        want_eos   = run && room && (sent_q[rr_q] == len_q[rr_q]) && !marked_q[rr_q];
    end

    assign rd_en   = want_fetch;
    assign rd_addr = {rr_q, sent_q[rr_q][OW-1:0]};

    // per-way lengths, address counters, markers and credits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q     <= '0;
            marked_q <= '0;
            for (int w = 0; w < W; w++) begin
                len_q[w] <= '0; sent_q[w] <= '0; cred_q[w] <= '0;
            end
        end else if (load) begin
            rr_q     <= '0;
            marked_q <= '0;
            for (int w = 0; w < W; w++) begin
                len_q[w]  <= lens[w*LW +: LW];
                sent_q[w] <= '0;
                cred_q[w] <= '0;
            end
        end else begin
            rr_q <= rr_q + 1'b1;
            if (want_fetch) sent_q[rr_q] <= sent_q[rr_q] + 1'b1;
            if (want_eos)   marked_q[rr_q] <= 1'b1;
            for (int w = 0; w < W; w++) begin
                cred_q[w] <= cred_q[w]
                    + CW'((want_fetch || want_eos) && (rr_q == WW'(w)))
                    - CW'(pop[w]);
            end
        end
    end

    // owner pipeline aligned with the memory latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                own_v[i] <= 1'b0; own_w[i] <= '0; own_e[i] <= 1'b0;
            end
        end else begin
            own_v[0] <= want_fetch || want_eos;
            own_w[0] <= rr_q;
            own_e[0] <= want_eos;
            for (int i = 1; i < LAT; i++) begin
                own_v[i] <= own_v[i-1]; own_w[i] <= own_w[i-1]; own_e[i] <= own_e[i-1];
            end
        end
    end

    assign fill_valid = own_v[LAT-1];
    assign fill_way   = own_w[LAT-1];
    assign fill_eos   = own_e[LAT-1];
endmodule

// File: rtl/merge_pick.sv
// W-input minimum selector over queue heads. Markers lose to any key; on
// equal keys the lowest way wins. Purely combinational.
module merge_pick #(
    parameter int unsigned W  = 4,
    parameter int unsigned KW = 16,
    localparam int unsigned WW = $clog2(W)
) (
    input  logic [W*KW-1:0] keys,
    input  logic [W-1:0]    eos,
    output logic            found,
    output logic [WW-1:0]   sel
);
    logic [KW-1:0] best;

    // linear scan with strict compare keeps the lowest way on ties
    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int w = 0; w < W; w++) begin
            if (!eos[w] && (!found || keys[w*KW +: KW] < best)) begin
                found = 1'b1;
                sel   = WW'(w);
                best  = keys[w*KW +: KW];
            end
        end
    end
endmodule

// File: rtl/merge_stream_top.sv
// Multi-way run merger: per-way prefetch queues filled by a rotating
// prefetcher, drained by a minimum selector into one registered output.
// Assumes a read port with fixed latency LAT and runs already sorted.
module merge_stream_top
    import merge_stream_pkg::*;
#(
    parameter int unsigned W       = DEF_WAYS,
    parameter int unsigned KW      = DEF_KEY_W,
    parameter int unsigned IW      = DEF_IDX_W,
    parameter int unsigned RUN_MAX = DEF_RUN_MAX,
    parameter int unsigned LAT     = DEF_LAT,
    parameter int unsigned QDEPTH  = DEF_QDEPTH,
    localparam int unsigned WW = $clog2(W),
    localparam int unsigned LW = $clog2(RUN_MAX + 1),
    localparam int unsigned AW = WW + $clog2(RUN_MAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W*LW-1:0] run_len,
    output logic            active,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [KW+IW-1:0] rd_data,
    output logic            out_valid,
    output logic [KW-1:0]   out_key,
    output logic [IW-1:0]   out_idx,
    output logic            done
);
    localparam int unsigned DW = 1 + KW + IW;

    logic          load;
    logic [W-1:0]  pop, empty, head_eos;
    logic [W*KW-1:0] head_keys;
    logic [DW-1:0] head [W];
    logic          fill_valid, fill_eos, found, all_ready;
    logic [WW-1:0] fill_way, sel;

    assign load = start && !active;

    merge_prefetch #(.W(W), .RUN_MAX(RUN_MAX), .LAT(LAT), .QDEPTH(QDEPTH)) u_pf (
        .clk(clk), .rst_n(rst_n), .load(load), .run(active), .lens(run_len),
        .pop(pop), .rd_en(rd_en), .rd_addr(rd_addr), .fill_valid(fill_valid),
        .fill_way(fill_way), .fill_eos(fill_eos)
    );

    for (genvar w = 0; w < W; w++) begin : g_way
        merge_way_fifo #(.DEPTH(QDEPTH), .DW(DW)) u_q (
            .clk(clk), .rst_n(rst_n),
            .wr(fill_valid && fill_way == WW'(w)),
            .wdata({fill_eos, rd_data}),
            .rd(pop[w]), .empty(empty[w]), .head(head[w])
        );
        assign head_eos[w]             = head[w][DW-1];
        assign head_keys[w*KW +: KW]   = head[w][KW+IW-1:IW];
    end

    merge_pick #(.W(W), .KW(KW)) u_pick (
        .keys(head_keys), .eos(head_eos), .found(found), .sel(sel)
    );

    assign all_ready = active && (empty == '0);

    // pop the winner, or every marker once all heads are markers
    always_comb begin
        pop = '0;
        if (all_ready) begin
            if (found) pop[sel] = 1'b1;
            else       pop      = '1;
        end
    end

    // output register, sequence state and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; out_valid <= 1'b0; done <= 1'b0;
            out_key <= '0; out_idx <= '0;
        end else begin
            out_valid <= all_ready && found;
            done      <= all_ready && !found;
            if (all_ready && found) begin
                out_key <= head[sel][KW+IW-1:IW];
                out_idx <= head[sel][IW-1:0];
            end
            if (load)                       active <= 1'b1;
            else if (all_ready && !found)   active <= 1'b0;
        end
    end
endmodule

// File: rtl/merge_stream_chk.sv
// Property checker for merge_stream_top, attached by bind below.
module merge_stream_chk #(
    parameter int unsigned KW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          rd_en,
    input logic          out_valid,
    input logic [KW-1:0] out_key,
    input logic          done
);
    logic          have_prev;
    logic [KW-1:0] prev_key;

    // remember the last key of the current merge
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            have_prev <= 1'b0; prev_key <= '0;
        end else if (out_valid) begin
            have_prev <= 1'b1; prev_key <= out_key;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !done && !rd_en && !active);
    // R2
    key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && have_prev |-> out_key >= prev_key);
    // R7
    done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !active);
    // R9
    read_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> active);
endmodule

bind merge_stream_top merge_stream_chk #(.KW(KW)) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .rd_en(rd_en),
    .out_valid(out_valid), .out_key(out_key), .done(done)
);

// File: tb/merge_stream_top_bench.sv
module merge_stream_top_bench;
    localparam int W = 4, KW = 16, IW = 8, RUN_MAX = 16, LAT = 4;
    localparam int LW = $clog2(RUN_MAX + 1);
    localparam int AW = $clog2(W) + $clog2(RUN_MAX);
    localparam int NMAX = W * RUN_MAX;

    logic clk = 0, rst_n = 0, start = 0;
    logic [W*LW-1:0] run_len = '0;
    logic active, rd_en, out_valid, done;
    logic [AW-1:0] rd_addr;
    logic [KW+IW-1:0] rd_data;
    logic [KW-1:0] out_key;
    logic [IW-1:0] out_idx;

    int checks = 0, errors = 0;
    logic [KW+IW-1:0] mem [NMAX];
    logic [KW+IW-1:0] pipe [LAT];
    logic [KW-1:0] obs_key [NMAX+8];
    logic [IW-1:0] obs_idx [NMAX+8];
    int n_obs = 0, n_rd = 0, n_done = 0, bad_rd = 0;
    int rd_hits [NMAX];
    int lens [W];
    logic [KW-1:0] exp_key [NMAX];
    logic [IW-1:0] exp_idx [NMAX];
    int n_exp;
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    merge_stream_top u_merge_stream_top (
        .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
        .active(active), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_key(out_key), .out_idx(out_idx), .done(done)
    );

    // fixed-latency memory model
    always @(posedge clk) begin
        pipe[0] <= mem[rd_addr];
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign rd_data = pipe[LAT-1];

    // observer, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && n_obs < NMAX + 8) begin
                obs_key[n_obs] = out_key; obs_idx[n_obs] = out_idx; n_obs++;
            end
            if (rd_en) begin
                n_rd++;
                if (int'(rd_addr[AW-1:$clog2(RUN_MAX)]) >= W ||
                    int'(rd_addr[$clog2(RUN_MAX)-1:0]) >= lens[rd_addr[AW-1:$clog2(RUN_MAX)]])
                    bad_rd++;
                else rd_hits[rd_addr]++;
            end
            if (done) n_done++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // step: 0 strictly rising, 1 all equal, 2 small random steps
    task automatic fill(input int l0, input int l1, input int l2, input int l3, input int mode);
        int k;
        lens[0] = l0; lens[1] = l1; lens[2] = l2; lens[3] = l3;
        for (int w = 0; w < W; w++) begin
            k = 3 * w + 1;
            for (int p = 0; p < RUN_MAX; p++) begin
                seed = seed * 1103515245 + 12345;
                if (mode == 0) k = k + 5 + w;
                else if (mode == 2) k = k + int'((seed >> 16) % 4);
                else k = 100;
                mem[w*RUN_MAX + p] = {KW'(k), IW'(w*RUN_MAX + p)};
            end
        end
        n_exp = 0;
        for (int w = 0; w < W; w++)
            for (int p = 0; p < lens[w]; p++) begin
                exp_key[n_exp] = mem[w*RUN_MAX+p][KW+IW-1:IW];
                exp_idx[n_exp] = mem[w*RUN_MAX+p][IW-1:0];
                n_exp++;
            end
        for (int i = 1; i < n_exp; i++)
            for (int j = i; j > 0 && exp_key[j] < exp_key[j-1]; j--) begin
                {exp_key[j], exp_key[j-1]} = {exp_key[j-1], exp_key[j]};
                {exp_idx[j], exp_idx[j-1]} = {exp_idx[j-1], exp_idx[j]};
            end
    endtask

    task automatic launch;
        n_obs = 0; n_rd = 0; n_done = 0; bad_rd = 0;
        for (int i = 0; i < NMAX; i++) rd_hits[i] = 0;
        @(negedge clk);
        for (int w = 0; w < W; w++) run_len[w*LW +: LW] = LW'(lens[w]);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic finish_and_check(input string tag);
        int t = 0, mism = 0, first = -1, hits_bad = 0;
        while (n_done == 0 && t < 2000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        check(n_done == 1, "R7", {tag, " done pulses"}, n_done, 1);
        check(!active, "R7", {tag, " idle after done"}, active, 0);
        check(n_obs == n_exp, "R3", {tag, " item count"}, n_obs, n_exp);
        for (int i = 0; i < n_exp && i < n_obs; i++)
            if (obs_key[i] != exp_key[i] || obs_idx[i] != exp_idx[i]) begin
                mism++; if (first < 0) first = i;
            end
        check(mism == 0, "R2 R4", {tag, " stream order, first bad idx"},
              first < 0 ? 0 : int'(obs_idx[first]), first < 0 ? 0 : int'(exp_idx[first]));
        for (int w = 0; w < W; w++)
            for (int p = 0; p < lens[w]; p++)
                if (rd_hits[w*RUN_MAX+p] != 1) hits_bad++;
        check(bad_rd == 0 && hits_bad == 0, "R5", {tag, " read addresses"}, bad_rd + hits_bad, 0);
        check(n_rd == n_exp, "R5", {tag, " read count"}, n_rd, n_exp);
    endtask

    task automatic t_rising;   fill(5, 3, 7, 2, 0); launch(); finish_and_check("rising"); endtask
    task automatic t_ties;     fill(4, 4, 4, 4, 1); launch(); finish_and_check("ties R4"); endtask
    task automatic t_empty_r6; fill(0, 6, 0, 1, 2); launch(); finish_and_check("some empty R6"); endtask
    task automatic t_all_empty_r6;
        fill(0, 0, 0, 0, 2); launch(); finish_and_check("all empty R6");
        check(n_obs == 0, "R6", "no output when empty", n_obs, 0);
    endtask
    task automatic t_full;     fill(16, 16, 16, 16, 2); launch(); finish_and_check("full"); endtask
    task automatic t_restart_r8;
        fill(3, 2, 6, 1, 2); launch();
        repeat (3) @(negedge clk);
        for (int w = 0; w < W; w++) run_len[w*LW +: LW] = LW'(RUN_MAX);
        start = 1; @(negedge clk); start = 0;
        finish_and_check("start while busy R8");
    endtask

    initial begin
        for (int i = 0; i < NMAX; i++) mem[i] = '0;
        for (int i = 0; i < W; i++) lens[i] = 0;
        repeat (3) @(negedge clk);
        check(!out_valid && !done && !rd_en && !active, "R1", "reset outputs",
              int'({out_valid, done, rd_en, active}), 0);
        rst_n = 1;
        @(negedge clk);
        check(!active && !rd_en, "R1 R9", "idle after reset", int'({active, rd_en}), 0);
        t_rising();
        t_ties();
        t_empty_r6();
        t_all_empty_r6();
        t_full();
        t_restart_r8();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule